// File: doc/BRIEF.md
# Processor Bus Cycle Strobe Generator

This block sits between a processor's time-multiplexed 16-bit information bus and the external memory and I/O devices. While the processor holds its address strobe high, the block captures the cycle address from the bus. With it the block captures the cycle type: memory or I/O, and read or write. While the active-low data strobe is held, it produces exactly one of four active-low strobes: memory read, memory write, I/O read or I/O write. Two fixed I/O addresses also raise dedicated strobes. An I/O write to 0x1000 gives an interrupt-acknowledge strobe, and an I/O read from 0x8410 gives a configuration-enable strobe.

A seventeenth bus line carries odd parity. The block drives it during write data phases and checks it at the end of read data phases. A failed check sets a sticky error flag. Both strobe inputs are asynchronous, and each passes through a synchronizer before it is used. A small control register holds two float-enable bits. When the external strobe-enable input is high, these bits let the address outputs and the strobe outputs go to high impedance. The pads see this as deasserted output enables.

Top module: `bcs_strobe_gen`

## Requirements
- R1: After reset, all six strobe outputs are high, `perr` is 0, `ib_par_oe` is 0, and both `addr_oe` and `strb_oe` are 1 (both float bits cleared).
- R2: `addr_out` takes the bus value present while the synchronized address strobe is high. It keeps that value after the strobe ends, whatever the bus carries later.
- R3: In a memory cycle (`mem_io`=1), `memr_n` (`rd_wr`=1) or `memw_n` (`rd_wr`=0) goes low on the third rising clock edge after `data_stb_n` falls, and stays low only while the synchronized data strobe is active.
- R4: In an I/O cycle (`mem_io`=0), `ior_n` or `iow_n` is produced instead, with the same timing as R3.
- R5: `inta_n` is low together with `iow_n` only for an I/O write whose latched address is 0x1000. A memory write to 0x1000 leaves it high.
- R6: `cfg_n` is low together with `ior_n` only for an I/O read whose latched address is 0x8410. A memory read from 0x8410 leaves it high.
- R7: During a write data phase, `ib_par_oe` is 1, and `ib_par_out` makes the 17 bits {`ib_par_out`, `ib_in`} hold an odd number of ones.
- R8: When a read data phase ends, the block tests the 17 bits {`ib_par_in`, `ib_in`}. An even count of ones sets `perr`. It stays set through later good reads until `perr_clr` is pulsed.
- R9: A pulse on `ctl_we` loads `ctl_wdata`. Bit 0 is the address float enable and bit 1 is the strobe float enable. `addr_oe` is 0 exactly when `stb_en_n` is 1 and bit 0 is set. `strb_oe` is 0 exactly when `stb_en_n` is 1 and bit 1 is set.
- R10: At most one of `memr_n`, `memw_n`, `ior_n`, `iow_n` is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ib_in | input | 16 | Information bus, address or data |
| ib_par_in | input | 1 | Parity line as received |
| ib_par_out | output | 1 | Parity line value driven on writes |
| ib_par_oe | output | 1 | Parity line drive enable |
| addr_stb | input | 1 | Asynchronous active-high address strobe |
| data_stb_n | input | 1 | Asynchronous active-low data strobe |
| mem_io | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| rd_wr | input | 1 | 1 for a read, 0 for a write |
| stb_en_n | input | 1 | External strobe enable, active low |
| ctl_we | input | 1 | Control register write pulse |
| ctl_wdata | input | 2 | Float enable bits: [0] address, [1] strobes |
| perr_clr | input | 1 | Clears the sticky parity error |
| addr_out | output | 16 | Latched cycle address |
| addr_oe | output | 1 | Address output enable |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| strb_oe | output | 1 | Output enable of the four strobes |
| inta_n | output | 1 | Interrupt acknowledge strobe |
| cfg_n | output | 1 | Configuration read strobe |
| perr | output | 1 | Sticky read parity error |

## Verification
The parity error is the hardest effect to reach, because it depends on a read data phase ending while the bus still holds the data and parity. The driver task keeps data and parity stable through the synchronizer delay after the data strobe is released. It deliberately presents even parity on one read. It then runs a good read to show that the flag stays set, and only after that pulses the clear. The special strobes are told apart from plain I/O by repeating the same two addresses as memory cycles.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned BUS_W = 16;

  typedef struct packed {
    logic mem;
    logic rd;
  } cyc_t;

  typedef struct packed {
    logic memr;
    logic memw;
    logic ior;
    logic iow;
    logic inta;
    logic cfg;
  } strb_t;

  function automatic logic odd_par(input logic [BUS_W-1:0] d);
    return ~(^d);
  endfunction

  function automatic logic par_ok(input logic [BUS_W-1:0] d, input logic p);
    return (^{p, d}) == 1'b1;
  endfunction

  function automatic strb_t decode(input logic act, input cyc_t c,
                                   input logic [BUS_W-1:0] a,
                                   input logic [BUS_W-1:0] inta_a,
                                   input logic [BUS_W-1:0] cfg_a);
    strb_t s;
    s.memr = act & c.mem & c.rd;
    s.memw = act & c.mem & ~c.rd;
    s.ior  = act & ~c.mem & c.rd;
    s.iow  = act & ~c.mem & ~c.rd;
    s.inta = s.iow & (a == inta_a);
    s.cfg  = s.ior & (a == cfg_a);
    return s;
  endfunction
endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/bcs_addr_latch.sv
module bcs_addr_latch import bcs_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] bus,
  input  logic             mem_io,
  input  logic             rd_wr,
  output logic [BUS_W-1:0] addr,
  output cyc_t             cyc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      cyc  <= '{mem: 1'b0, rd: 1'b1};
    end else if (load) begin
      addr <= bus;
      cyc  <= '{mem: mem_io, rd: rd_wr};
    end
  end
endmodule

// File: rtl/bcs_strobe_dec.sv
module bcs_strobe_dec import bcs_pkg::*; #(
  parameter logic [BUS_W-1:0] INTA_ADDR = 16'h1000,
  parameter logic [BUS_W-1:0] CFG_ADDR  = 16'h8410
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ds_act,
  input  cyc_t             cyc,
  input  logic [BUS_W-1:0] addr,
  output strb_t            strb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb <= '0;
    else        strb <= decode(ds_act, cyc, addr, INTA_ADDR, CFG_ADDR);
  end
endmodule

// File: rtl/bcs_parity.sv
module bcs_parity import bcs_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ds_act,
  input  logic             chk_evt,
  input  logic             rd,
  input  logic [BUS_W-1:0] bus,
  input  logic             par_in,
  input  logic             clr,
  output logic             par_out,
  output logic             par_oe,
  output logic             perr
);
  logic [BUS_W-1:0] dat_q;
  logic             par_q;
  logic             perr_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q   <= '0;
      par_q   <= 1'b1;
      par_out <= 1'b1;
      par_oe  <= 1'b0;
    end else begin
      par_oe <= ds_act & ~rd;
      if (ds_act) begin
        dat_q   <= bus;
        par_q   <= par_in;
        par_out <= odd_par(bus);
      end
    end
  end

  assign perr_set = chk_evt & rd & ~par_ok(dat_q, par_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        perr <= 1'b0;
    else if (perr_set) perr <= 1'b1;
    else if (clr)      perr <= 1'b0;
  end
endmodule

// File: rtl/bcs_float_ctl.sv
module bcs_float_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] wdata,
  input  logic       stb_en_n,
  output logic       addr_oe,
  output logic       strb_oe
);
  logic [1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= 2'b00;
    else if (we) ctl_q <= wdata;
  end

  assign addr_oe = ~(stb_en_n & ctl_q[0]);
  assign strb_oe = ~(stb_en_n & ctl_q[1]);
endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen import bcs_pkg::*; #(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [BUS_W-1:0] INTA_ADDR   = 16'h1000,
  parameter logic [BUS_W-1:0] CFG_ADDR    = 16'h8410
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] ib_in,
  input  logic             ib_par_in,
  output logic             ib_par_out,
  output logic             ib_par_oe,
  input  logic             addr_stb,
  input  logic             data_stb_n,
  input  logic             mem_io,
  input  logic             rd_wr,
  input  logic             stb_en_n,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_wdata,
  input  logic             perr_clr,
  output logic [BUS_W-1:0] addr_out,
  output logic             addr_oe,
  output logic             memr_n,
  output logic             memw_n,
  output logic             ior_n,
  output logic             iow_n,
  output logic             strb_oe,
  output logic             inta_n,
  output logic             cfg_n,
  output logic             perr
);
  logic  as_act;
  logic  ds_act;
  logic  ds_dly;
  logic  chk_evt;
  logic  ds_raw;
  cyc_t  cyc;
  strb_t strb;

  assign ds_raw = ~data_stb_n;

  bcs_sync #(.STAGES(SYNC_STAGES)) u_as_sync (
    .clk(clk), .rst_n(rst_n), .d(addr_stb), .q(as_act));

  bcs_sync #(.STAGES(SYNC_STAGES)) u_ds_sync (
    .clk(clk), .rst_n(rst_n), .d(ds_raw), .q(ds_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ds_dly <= 1'b0;
    else        ds_dly <= ds_act;
  end

  assign chk_evt = ds_dly & ~ds_act;

  bcs_addr_latch u_latch (
    .clk(clk), .rst_n(rst_n), .load(as_act), .bus(ib_in),
    .mem_io(mem_io), .rd_wr(rd_wr), .addr(addr_out), .cyc(cyc));

  bcs_strobe_dec #(.INTA_ADDR(INTA_ADDR), .CFG_ADDR(CFG_ADDR)) u_dec (
    .clk(clk), .rst_n(rst_n), .ds_act(ds_act), .cyc(cyc),
    .addr(addr_out), .strb(strb));

  bcs_parity u_par (
    .clk(clk), .rst_n(rst_n), .ds_act(ds_act), .chk_evt(chk_evt),
    .rd(cyc.rd), .bus(ib_in), .par_in(ib_par_in), .clr(perr_clr),
    .par_out(ib_par_out), .par_oe(ib_par_oe), .perr(perr));

  bcs_float_ctl u_float (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .stb_en_n(stb_en_n), .addr_oe(addr_oe), .strb_oe(strb_oe));

  assign memr_n = ~strb.memr;
  assign memw_n = ~strb.memw;
  assign ior_n  = ~strb.ior;
  assign iow_n  = ~strb.iow;
  assign inta_n = ~strb.inta;
  assign cfg_n  = ~strb.cfg;
endmodule

// File: rtl/bcs_strobe_gen_chk.sv
module bcs_strobe_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        memr_n,
  input logic        memw_n,
  input logic        ior_n,
  input logic        iow_n,
  input logic        inta_n,
  input logic        cfg_n,
  input logic [15:0] ib_in,
  input logic        ib_par_out,
  input logic        ib_par_oe,
  input logic        perr,
  input logic        perr_clr,
  input logic        ds_act,
  input logic        chk_evt,
  input logic        ctl_we,
  input logic [1:0]  ctl_wdata,
  input logic        strb_oe
);
  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{memr_n, memw_n, ior_n, iow_n}));

  // R3
  memr_follows_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !memr_n |-> $past(ds_act));

  // R5
  inta_with_iow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |-> !iow_n);

  // R6
  cfg_with_ior_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_n |-> !ior_n);

  // R7
  write_par_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ib_par_oe |-> (^{ib_par_out, $past(ib_in)}) == 1'b1);

  // R8
  perr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> $past(chk_evt));

  // R8
  perr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_clr && !chk_evt) |=> !perr);

  // R9
  strb_float_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[1]) |=> strb_oe);
endmodule

bind bcs_strobe_gen bcs_strobe_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .memr_n(memr_n), .memw_n(memw_n),
  .ior_n(ior_n), .iow_n(iow_n), .inta_n(inta_n), .cfg_n(cfg_n),
  .ib_in(ib_in), .ib_par_out(ib_par_out), .ib_par_oe(ib_par_oe),
  .perr(perr), .perr_clr(perr_clr), .ds_act(ds_act), .chk_evt(chk_evt),
  .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .strb_oe(strb_oe));

// File: tb/bcs_strobe_gen_test.sv
module bcs_strobe_gen_test;
  typedef struct packed {
    logic [15:0] addr;
    logic [5:0]  strb;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ib_in = '0;
  logic ib_par_in = 1'b0;
  logic addr_stb = 1'b0;
  logic data_stb_n = 1'b1;
  logic mem_io = 1'b0;
  logic rd_wr = 1'b1;
  logic stb_en_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [1:0] ctl_wdata = 2'b00;
  logic perr_clr = 1'b0;
  logic ib_par_out, ib_par_oe, addr_oe, strb_oe, perr;
  logic memr_n, memw_n, ior_n, iow_n, inta_n, cfg_n;
  logic [15:0] addr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t sb_q[$];
  logic [5:0] cur_s;
  logic [5:0] prev_s = '0;

  always #5 clk = ~clk;

  bcs_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .ib_in(ib_in), .ib_par_in(ib_par_in),
    .ib_par_out(ib_par_out), .ib_par_oe(ib_par_oe), .addr_stb(addr_stb),
    .data_stb_n(data_stb_n), .mem_io(mem_io), .rd_wr(rd_wr),
    .stb_en_n(stb_en_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .perr_clr(perr_clr), .addr_out(addr_out), .addr_oe(addr_oe),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
    .strb_oe(strb_oe), .inta_n(inta_n), .cfg_n(cfg_n), .perr(perr));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobe order: memr memw ior iow inta cfg
  task automatic bus_cycle(input logic [15:0] a, input logic mem, input logic rd,
                           input logic [15:0] d, input bit good_par,
                           input logic [5:0] exp_s);
    sb_q.push_back('{addr: a, strb: exp_s});
    @(negedge clk);
    ib_in = a; mem_io = mem; rd_wr = rd; addr_stb = 1'b1;
    repeat (3) @(negedge clk);
    addr_stb = 1'b0;
    repeat (3) @(negedge clk);
    ib_in = d;
    ib_par_in = good_par ? ~(^d) : (^d);
    data_stb_n = 1'b0;
    repeat (4) @(negedge clk);
    if (!rd) begin
      chk(ib_par_oe == 1'b1, "R7 par_oe", 32'(ib_par_oe), 32'd1);
      chk((^{ib_par_out, d}) == 1'b1, "R7 parity", 32'(ib_par_out), 32'(~(^d)));
    end else begin
      chk(ib_par_oe == 1'b0, "R7 no drive on read", 32'(ib_par_oe), 32'd0);
    end
    repeat (2) @(negedge clk);
    data_stb_n = 1'b1;
    repeat (6) @(negedge clk);
    ib_in = 16'hA5C3;
    @(negedge clk);
    chk(addr_out == a, "R2 address held", 32'(addr_out), 32'(a));
  endtask

  // scoreboard monitor: one item per strobe onset
  always @(negedge clk) begin
    if (rst_n) begin
      cur_s = ~{memr_n, memw_n, ior_n, iow_n, inta_n, cfg_n};
      if (cur_s != 6'b0 && prev_s == 6'b0) begin
        chk($countones(cur_s[5:2]) == 1, "R10 single strobe", 32'(cur_s), 32'd0);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3/R4 unexpected strobe", 32'(cur_s), 32'd0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          chk(cur_s == it.strb, "R3 R4 R5 R6 strobe set", 32'(cur_s), 32'(it.strb));
          chk(addr_out == it.addr, "R2 cycle address", 32'(addr_out), 32'(it.addr));
        end
      end
      prev_s = cur_s;
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic ctl_write(input logic [1:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({memr_n, memw_n, ior_n, iow_n, inta_n, cfg_n} == 6'h3F, "R1 strobes",
        32'({memr_n, memw_n, ior_n, iow_n, inta_n, cfg_n}), 32'h3F);
    chk(perr == 1'b0, "R1 perr", 32'(perr), 32'd0);
    chk(ib_par_oe == 1'b0, "R1 par_oe", 32'(ib_par_oe), 32'd0);
    stb_en_n = 1'b1;
    @(negedge clk);
    chk(addr_oe && strb_oe, "R1 float bits cleared", 32'({addr_oe, strb_oe}), 32'd3);
    stb_en_n = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 memory read / write
    bus_cycle(16'h1234, 1'b1, 1'b1, 16'h0F0F, 1'b1, 6'b100000);
    bus_cycle(16'h00FF, 1'b1, 1'b0, 16'h1357, 1'b1, 6'b010000);
    // R4 I/O read / write
    bus_cycle(16'h0042, 1'b0, 1'b1, 16'h8001, 1'b1, 6'b001000);
    bus_cycle(16'h0300, 1'b0, 1'b0, 16'hFFFE, 1'b1, 6'b000100);
    // R5 interrupt acknowledge, and a memory write to the same address
    bus_cycle(16'h1000, 1'b0, 1'b0, 16'h0000, 1'b1, 6'b000110);
    bus_cycle(16'h1000, 1'b1, 1'b0, 16'h0001, 1'b1, 6'b010000);
    // R6 configuration read, and a memory read from the same address
    bus_cycle(16'h8410, 1'b0, 1'b1, 16'h7777, 1'b1, 6'b001001);
    bus_cycle(16'h8410, 1'b1, 1'b1, 16'h7777, 1'b1, 6'b100000);
    chk(perr == 1'b0, "R8 good reads leave perr clear", 32'(perr), 32'd0);

    // R8 bad parity sets, good read keeps, clear drops
    bus_cycle(16'h2222, 1'b1, 1'b1, 16'hC0DE, 1'b0, 6'b100000);
    chk(perr == 1'b1, "R8 perr set", 32'(perr), 32'd1);
    bus_cycle(16'h2224, 1'b0, 1'b1, 16'h0101, 1'b1, 6'b001000);
    chk(perr == 1'b1, "R8 perr sticky", 32'(perr), 32'd1);
    @(negedge clk); perr_clr = 1'b1;
    @(negedge clk); perr_clr = 1'b0;
    chk(perr == 1'b0, "R8 perr cleared", 32'(perr), 32'd0);

    // R9 float control
    ctl_write(2'b01);
    stb_en_n = 1'b1;
    @(negedge clk);
    chk({addr_oe, strb_oe} == 2'b01, "R9 addr float only", 32'({addr_oe, strb_oe}), 32'd1);
    ctl_write(2'b11);
    @(negedge clk);
    chk({addr_oe, strb_oe} == 2'b00, "R9 both float", 32'({addr_oe, strb_oe}), 32'd0);
    stb_en_n = 1'b0;
    @(negedge clk);
    chk({addr_oe, strb_oe} == 2'b11, "R9 enable low drives", 32'({addr_oe, strb_oe}), 32'd3);
    ctl_write(2'b10);
    stb_en_n = 1'b1;
    @(negedge clk);
    chk({addr_oe, strb_oe} == 2'b10, "R9 strobe float only", 32'({addr_oe, strb_oe}), 32'd2);
    ctl_write(2'b00);
    @(negedge clk);
    chk({addr_oe, strb_oe} == 2'b11, "R9 bits cleared", 32'({addr_oe, strb_oe}), 32'd3);
    stb_en_n = 1'b0;

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R3 R4 all expected strobes seen", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule